// File: doc/BRIEF.md
# Fat-Tree Up/Down Routing Switch

This block is a single switch node in a fat-tree data network. Child ports face the leaves and parent ports face the root. There are more parent links than the one a plain tree would give, so traffic heading rootward has spare capacity.

A message is a train of flits. The first flit carries the destination leaf address in its low bits. The last flit is marked with a last flag.

When a header arrives from a child and its destination lies outside this node's subtree, the message climbs. It takes one of the parent links that is free at that moment. The choice comes from a free-running pseudo-random index that rotates to the next free link. When the destination lies inside the subtree, or the message comes from a parent, it descends to the one child port named by this level's address bits. No choice is made on the way down.

A granted path stays open until the last flit has been transferred. Flits then flow straight through under valid/ready flow control. Headers whose address falls outside the partition range are flagged on `err_o` and swallowed.

Top module: `fatsw_node`

## Requirements
- R1: While reset is held and no input is valid, every output valid, every input ready and every `err_o` bit is 0.
- R2: A header from a child input with destination bits above bit CB*(LEVEL+1) equal to the same bits of `prefix_i` goes to child output `dest[CB*LEVEL +: CB]`. The destination is `data[ADDR_W-1:0]`; with the defaults, bits 7:4 are compared and bits 3:2 pick the child. The path is visible on the output in the cycle after the header is presented to an idle node.
- R3: A header arriving on a parent input always descends to the child named by the same index bits, whatever its upper bits.
- R4: A header from a child input whose destination lies outside the subtree appears on exactly one parent output.
- R5: The climbing route starts its search at the LFSR value modulo NP and takes the first free parent from there, all within the grant cycle. Under varied traffic with all parents free, every parent gets used.
- R6: While all parents are held, a climbing header is stalled with ready low. It is granted the parent that frees first, in the cycle after that parent's tail is transferred.
- R7: An output stays bound to its message until that message's last flit is transferred. A competing header for that output sees ready low, and the output keeps showing the first message.
- R8: Headers contending for one child output are granted in round-robin order, so two persistent senders alternate.
- R9: A header with destination below `part_lo_i` or above `part_hi_i` raises its input's `err_o` bit while it waits at an idle input. Its flits are then accepted with ready high and driven onto no output.
- R10: On an open path the output data, valid and last equal the input's in the same cycle, and the input ready equals the output ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prefix_i | input | ADDR_W (8) | Leaf address inside this node's subtree; upper bits define the subtree |
| part_lo_i | input | ADDR_W (8) | Lowest legal destination |
| part_hi_i | input | ADDR_W (8) | Highest legal destination |
| cin_valid_i | input | NC (4) | Flit valid from each child |
| cin_data_i | input | NC x W (4x16) | Flit data from each child |
| cin_last_i | input | NC (4) | Last-flit flag from each child |
| cin_ready_o | output | NC (4) | Ready toward each child |
| pin_valid_i | input | NP (2) | Flit valid from each parent |
| pin_data_i | input | NP x W (2x16) | Flit data from each parent |
| pin_last_i | input | NP (2) | Last-flit flag from each parent |
| pin_ready_o | output | NP (2) | Ready toward each parent |
| cout_valid_o | output | NC (4) | Flit valid toward each child |
| cout_data_o | output | NC x W (4x16) | Flit data toward each child |
| cout_last_o | output | NC (4) | Last-flit flag toward each child |
| cout_ready_i | input | NC (4) | Ready from each child |
| pout_valid_o | output | NP (2) | Flit valid toward each parent |
| pout_data_o | output | NP x W (2x16) | Flit data toward each parent |
| pout_last_o | output | NP (2) | Last-flit flag toward each parent |
| pout_ready_i | input | NP (2) | Ready from each parent |
| err_o | output | NC+NP (6) | Per input (children first), header outside the partition |

## Verification
A corrupted input or output binding shows up one cycle after a header is presented. The flit either appears on the wrong port, on two ports, or on none. A lost release leaves a later header with ready low, and a held tail shows it at once. A stuck round-robin pointer shows up as the same sender winning twice in a row. A bad parent pick shows up as a climbing flit that overwrites, or never reaches, a parent already carrying another message.

// File: rtl/fatsw_pkg.sv
package fatsw_pkg;
  typedef enum logic [1:0] {IN_IDLE, IN_FWD, IN_DROP} in_st_e;
endpackage

// File: rtl/fatsw_lfsr.sv
module fatsw_lfsr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   TAPS = 'hB8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= W'(1);
    else         state_o <= (state_o >> 1) ^ (state_o[0] ? TAPS : '0);
  end

  // a zero state would freeze the parent choice
  p_lfsr_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) state_o != '0);
endmodule

// File: rtl/fatsw_rr_arb.sv
module fatsw_rr_arb #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, win;
  logic          any;

  // scan downward so the request nearest the pointer wins
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_q) + k) % N]) begin
        win = IW'((int'(ptr_q) + k) % N);
        any = 1'b1;
      end
    end
    gnt_o = any ? (N'(1) << win) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (any) ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
  end

  p_gnt_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));
  p_gnt_in_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/fatsw_up_pick.sv
module fatsw_up_pick #(
  parameter int NP = 2,
  parameter int RW = 8,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [RW-1:0] rnd_i,
  input  logic [NP-1:0] busy_i,
  output logic [PW-1:0] sel_o,
  output logic          ok_o
);
  logic [PW-1:0] start;
  assign start = PW'(rnd_i % NP);

  // rotate from the random start to the first free parent
  always_comb begin
    sel_o = '0;
    ok_o  = 1'b0;
    for (int k = NP - 1; k >= 0; k--) begin
      if (!busy_i[(int'(start) + k) % NP]) begin
        sel_o = PW'((int'(start) + k) % NP);
        ok_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fatsw_node.sv
module fatsw_node
  import fatsw_pkg::*;
#(
  parameter int           CB        = 2,
  parameter int           NC        = 1 << CB,
  parameter int           NP        = 2,
  parameter int           ADDR_W    = 8,
  parameter int           W         = 16,
  parameter int           LEVEL     = 1,
  parameter int           LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 'hB8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        prefix_i,
  input  logic [ADDR_W-1:0]        part_lo_i,
  input  logic [ADDR_W-1:0]        part_hi_i,
  input  logic [NC-1:0]            cin_valid_i,
  input  logic [NC-1:0][W-1:0]     cin_data_i,
  input  logic [NC-1:0]            cin_last_i,
  output logic [NC-1:0]            cin_ready_o,
  input  logic [NP-1:0]            pin_valid_i,
  input  logic [NP-1:0][W-1:0]     pin_data_i,
  input  logic [NP-1:0]            pin_last_i,
  output logic [NP-1:0]            pin_ready_o,
  output logic [NC-1:0]            cout_valid_o,
  output logic [NC-1:0][W-1:0]     cout_data_o,
  output logic [NC-1:0]            cout_last_o,
  input  logic [NC-1:0]            cout_ready_i,
  output logic [NP-1:0]            pout_valid_o,
  output logic [NP-1:0][W-1:0]     pout_data_o,
  output logic [NP-1:0]            pout_last_o,
  input  logic [NP-1:0]            pout_ready_i,
  output logic [NC+NP-1:0]         err_o
);
  localparam int NI  = NC + NP;
  localparam int NO  = NC + NP;
  localparam int OIW = $clog2(NO);
  localparam int IIW = $clog2(NI);
  localparam int SH  = CB * (LEVEL + 1);
  localparam int PW  = (NP > 1) ? $clog2(NP) : 1;

  // unified views: children occupy the low indices
  logic [NI-1:0]        in_v, in_l, in_rdy, xfer_last;
  logic [NI-1:0][W-1:0] in_d;
  logic [NO-1:0]        out_v, out_l, out_rdy;
  logic [NO-1:0][W-1:0] out_d;

  assign in_v    = {pin_valid_i, cin_valid_i};
  assign in_l    = {pin_last_i, cin_last_i};
  assign in_d    = {pin_data_i, cin_data_i};
  assign out_rdy = {pout_ready_i, cout_ready_i};

  assign cin_ready_o  = in_rdy[NC-1:0];
  assign pin_ready_o  = in_rdy[NI-1:NC];
  assign cout_valid_o = out_v[NC-1:0];
  assign pout_valid_o = out_v[NO-1:NC];
  assign cout_last_o  = out_l[NC-1:0];
  assign pout_last_o  = out_l[NO-1:NC];
  assign cout_data_o  = out_d[NC-1:0];
  assign pout_data_o  = out_d[NO-1:NC];

  in_st_e        in_st   [NI];
  logic [OIW-1:0] in_port [NI];
  logic [NO-1:0]  out_busy;
  logic [IIW-1:0] out_own [NO];

  logic [NI-1:0] hdr, oor, up, up_req, up_gnt;
  logic [CB-1:0] cidx [NI];
  logic [NI-1:0] dn_gnt [NC];
  logic [LFSR_W-1:0] rnd;
  logic [PW-1:0]     up_sel;
  logic              par_ok;

  // header decode per input
  for (genvar gi = 0; gi < NI; gi++) begin : g_dec
    logic [ADDR_W-1:0] dest;
    assign dest       = in_d[gi][ADDR_W-1:0];
    assign oor[gi]    = (dest < part_lo_i) || (dest > part_hi_i);
    assign cidx[gi]   = dest[CB*LEVEL +: CB];
    assign hdr[gi]    = (in_st[gi] == IN_IDLE) && in_v[gi];
    assign err_o[gi]  = hdr[gi] && oor[gi];
    if (gi < NC) begin : g_child
      assign up[gi] = (dest >> SH) != (prefix_i >> SH);
    end else begin : g_parent
      assign up[gi] = 1'b0;
    end
    assign up_req[gi] = hdr[gi] && !oor[gi] && up[gi] && par_ok;
  end

  // one arbiter per child output
  for (genvar gc = 0; gc < NC; gc++) begin : g_down
    logic [NI-1:0] req;
    always_comb begin
      for (int i = 0; i < NI; i++)
        req[i] = hdr[i] && !oor[i] && !up[i] && (cidx[i] == CB'(gc)) && !out_busy[gc];
    end
    fatsw_rr_arb #(.N(NI)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req),
      .gnt_o (dn_gnt[gc])
    );
  end

  // one climbing grant per cycle
  fatsw_rr_arb #(.N(NI)) u_up_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (up_req),
    .gnt_o (up_gnt)
  );

  fatsw_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(rnd)
  );

  fatsw_up_pick #(.NP(NP), .RW(LFSR_W)) u_pick (
    .rnd_i (rnd),
    .busy_i(out_busy[NO-1:NC]),
    .sel_o (up_sel),
    .ok_o  (par_ok)
  );

  // datapath through open paths
  always_comb begin
    for (int i = 0; i < NI; i++) begin
      case (in_st[i])
        IN_FWD:  in_rdy[i] = out_rdy[in_port[i]];
        IN_DROP: in_rdy[i] = 1'b1;
        default: in_rdy[i] = 1'b0;
      endcase
      xfer_last[i] = in_v[i] && in_rdy[i] && in_l[i];
    end
    for (int o = 0; o < NO; o++) begin
      out_v[o] = out_busy[o] && in_v[out_own[o]];
      out_l[o] = out_busy[o] && in_l[out_own[o]];
      out_d[o] = in_d[out_own[o]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_busy <= '0;
      for (int i = 0; i < NI; i++) begin
        in_st[i]   <= IN_IDLE;
        in_port[i] <= '0;
      end
      for (int o = 0; o < NO; o++) out_own[o] <= '0;
    end else begin
      for (int i = 0; i < NI; i++) begin
        case (in_st[i])
          IN_IDLE: begin
            if (err_o[i]) begin
              in_st[i] <= IN_DROP;
            end else if (up_gnt[i]) begin
              in_st[i]   <= IN_FWD;
              in_port[i] <= OIW'(NC) + OIW'(up_sel);
            end else begin
              for (int c = 0; c < NC; c++) begin
                if (dn_gnt[c][i]) begin
                  in_st[i]   <= IN_FWD;
                  in_port[i] <= OIW'(c);
                end
              end
            end
          end
          default: if (xfer_last[i]) in_st[i] <= IN_IDLE;
        endcase
      end
      for (int o = 0; o < NO; o++)
        if (out_busy[o] && xfer_last[out_own[o]]) out_busy[o] <= 1'b0;
      for (int c = 0; c < NC; c++) begin
        for (int i = 0; i < NI; i++) begin
          if (dn_gnt[c][i]) begin
            out_busy[c] <= 1'b1;
            out_own[c]  <= IIW'(i);
          end
        end
      end
      for (int i = 0; i < NI; i++) begin
        if (up_gnt[i]) begin
          out_busy[NC+up_sel] <= 1'b1;
          out_own[NC+up_sel]  <= IIW'(i);
        end
      end
    end
  end

  p_up_to_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|up_gnt) |-> !out_busy[NC+up_sel]);
  p_stall_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&out_busy[NO-1:NC]) |-> (up_gnt == '0));

  for (genvar go = 0; go < NO; go++) begin : g_chk_out
    p_path_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_busy[go] && !xfer_last[out_own[go]]) |=> (out_busy[go] && $stable(out_own[go])));
    if (go >= NC) begin : g_par
      p_parent_from_child_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_busy[go] |-> (out_own[go] < IIW'(NC)));
    end
  end

  for (genvar gi = 0; gi < NI; gi++) begin : g_chk_in
    p_err_drains_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o[gi] |=> in_rdy[gi]);
  end
endmodule

// File: tb/fatsw_node_bench.sv
module fatsw_node_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]       prefix = 8'h50, part_lo = 8'h10, part_hi = 8'hEF;
  logic [3:0]       cin_valid, cin_last, cin_ready;
  logic [3:0][15:0] cin_data;
  logic [1:0]       pin_valid, pin_last, pin_ready;
  logic [1:0][15:0] pin_data;
  logic [3:0]       cout_valid, cout_last, cout_ready;
  logic [3:0][15:0] cout_data;
  logic [1:0]       pout_valid, pout_last, pout_ready;
  logic [1:0][15:0] pout_data;
  logic [5:0]       err;

  int checks = 0, errors = 0;
  int hits [2];
  bit done = 0;

  fatsw_node u_fatsw_node (
    .clk_i(clk), .rst_ni(rst_ni), .prefix_i(prefix), .part_lo_i(part_lo), .part_hi_i(part_hi),
    .cin_valid_i(cin_valid), .cin_data_i(cin_data), .cin_last_i(cin_last), .cin_ready_o(cin_ready),
    .pin_valid_i(pin_valid), .pin_data_i(pin_data), .pin_last_i(pin_last), .pin_ready_o(pin_ready),
    .cout_valid_o(cout_valid), .cout_data_o(cout_data), .cout_last_o(cout_last), .cout_ready_i(cout_ready),
    .pout_valid_o(pout_valid), .pout_data_o(pout_data), .pout_last_o(pout_last), .pout_ready_i(pout_ready),
    .err_o(err)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic drive(input int i, input logic v, input logic [15:0] d, input logic l);
    if (i < 4) begin cin_valid[i] = v; cin_data[i] = d; cin_last[i] = l; end
    else begin pin_valid[i-4] = v; pin_data[i-4] = d; pin_last[i-4] = l; end
  endtask

  function automatic logic rdy(input int i);
    return (i < 4) ? cin_ready[i] : pin_ready[i-4];
  endfunction

  // -2 error, -1 climb, else child index
  function automatic int exp_route(input int src, input logic [7:0] dest);
    if (dest < 8'h10 || dest > 8'hEF) return -2;
    if (src < 4 && dest[7:4] != 4'h5) return -1;
    return int'(dest[3:2]);
  endfunction

  task automatic single_msg(input int src, input logic [7:0] dest, input logic [7:0] pl);
    logic [15:0] d;
    int e;
    d = {pl, dest};
    e = exp_route(src, dest);
    @(negedge clk);
    drive(src, 1'b1, d, 1'b1);
    #1;
    chk(err[src] == (e == -2), "R9", int'(err[src]), int'(e == -2));
    @(negedge clk);
    chk(rdy(src) == 1'b1, (e == -2) ? "R9" : "R10", int'(rdy(src)), 1);
    if (e == -2) begin
      chk(cout_valid == 0 && pout_valid == 0, "R9", int'({pout_valid, cout_valid}), 0);
    end else if (e >= 0) begin
      chk(cout_valid == (4'b1 << e) && pout_valid == 0, (src >= 4) ? "R3" : "R2",
          int'({pout_valid, cout_valid}), 1 << e);
      chk(cout_data[e] == d, "R10", int'(cout_data[e]), int'(d));
    end else begin
      chk($countones(pout_valid) == 1 && cout_valid == 0, "R4", int'({pout_valid, cout_valid}), 1);
      for (int p = 0; p < 2; p++) begin
        if (pout_valid[p]) begin
          chk(pout_data[p] == d, "R4", int'(pout_data[p]), int'(d));
          hits[p]++;
        end
      end
    end
    @(negedge clk);
    drive(src, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pc0, recs, prev, owner;
    void'($urandom(32'd7));
    cin_valid = '0; cin_last = '0; cin_data = '0;
    pin_valid = '0; pin_last = '0; pin_data = '0;
    cout_ready = '1; pout_ready = '1;
    hits[0] = 0; hits[1] = 0;
    repeat (3) @(negedge clk);
    chk(cout_valid == 0 && pout_valid == 0 && cin_ready == 0 && pin_ready == 0 && err == 0,
        "R1", int'({pout_valid, cout_valid}), 0);
    rst_ni = 1'b1;

    // directed routes
    single_msg(0, 8'h58, 8'h01);
    single_msg(2, 8'h80, 8'h02);
    single_msg(4, 8'h9C, 8'h03);
    single_msg(5, 8'h50, 8'h04);
    single_msg(3, 8'h5C, 8'h05);
    single_msg(1, 8'h05, 8'h06);
    single_msg(3, 8'hF3, 8'h07);
    single_msg(0, 8'h10, 8'h08);

    // R7/R10: held path with backpressure, competing header from a parent
    @(negedge clk);
    cout_ready[2] = 1'b0;
    drive(0, 1'b1, 16'h1158, 1'b0);
    @(negedge clk);
    chk(cout_valid[2] && cout_data[2] == 16'h1158, "R2", int'(cout_data[2]), 16'h1158);
    chk(rdy(0) == 1'b0, "R10", int'(rdy(0)), 0);
    drive(4, 1'b1, 16'h2258, 1'b1);
    @(negedge clk);
    chk(rdy(4) == 1'b0, "R7", int'(rdy(4)), 0);
    chk(cout_data[2] == 16'h1158, "R7", int'(cout_data[2]), 16'h1158);
    cout_ready[2] = 1'b1;
    #1;
    chk(rdy(0) == 1'b1, "R10", int'(rdy(0)), 1);
    @(negedge clk);
    chk(rdy(4) == 1'b0, "R7", int'(rdy(4)), 0);
    drive(0, 1'b1, 16'h3300, 1'b1);
    #1;
    chk(cout_data[2] == 16'h3300 && cout_last[2], "R10", int'(cout_data[2]), 16'h3300);
    @(negedge clk);
    drive(0, 1'b0, 16'h0, 1'b0);
    #1;
    chk(cout_valid[2] == 1'b0, "R7", int'(cout_valid[2]), 0);
    @(negedge clk);
    chk(cout_valid[2] && cout_data[2] == 16'h2258, "R7", int'(cout_data[2]), 16'h2258);
    @(negedge clk);
    drive(4, 1'b0, 16'h0, 1'b0);

    // R6: both parents held, third climber waits for the first freed one
    @(negedge clk);
    drive(0, 1'b1, 16'hA180, 1'b0);
    drive(1, 1'b1, 16'hB190, 1'b0);
    repeat (2) @(negedge clk);
    chk($countones(pout_valid) == 2, "R6", int'(pout_valid), 3);
    pc0 = -1;
    for (int p = 0; p < 2; p++) if (pout_data[p] == 16'hA180) pc0 = p;
    chk(pc0 >= 0, "R4", pc0, 0);
    if (pc0 < 0) pc0 = 0;
    drive(2, 1'b1, 16'hC1A0, 1'b1);
    repeat (2) begin
      @(negedge clk);
      chk(rdy(2) == 1'b0, "R6", int'(rdy(2)), 0);
      chk(pout_data[pc0] == 16'hA180, "R7", int'(pout_data[pc0]), 16'hA180);
    end
    drive(0, 1'b1, 16'hA180, 1'b1);
    @(negedge clk);
    drive(0, 1'b0, 16'h0, 1'b0);
    chk(rdy(2) == 1'b0, "R6", int'(rdy(2)), 0);
    @(negedge clk);
    chk(pout_valid[pc0] && pout_data[pc0] == 16'hC1A0, "R6", int'(pout_data[pc0]), 16'hC1A0);
    @(negedge clk);
    drive(2, 1'b0, 16'h0, 1'b0);
    drive(1, 1'b1, 16'hB190, 1'b1);
    @(negedge clk);
    drive(1, 1'b0, 16'h0, 1'b0);

    // R8: two persistent senders to child 1 alternate
    @(negedge clk);
    drive(1, 1'b1, 16'h0154, 1'b1);
    drive(3, 1'b1, 16'h0354, 1'b1);
    recs = 0; prev = -1; owner = 1;
    for (int n = 0; n < 40 && recs < 8; n++) begin
      @(negedge clk);
      if (cout_valid[1]) begin
        owner = int'(cout_data[1][15:8]);
        if (prev >= 0) chk(owner != prev, "R8", owner, 4 - prev);
        prev = owner;
        recs++;
      end
    end
    chk(recs == 8, "R8", recs, 8);
    drive(4 - owner, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    drive(owner, 1'b0, 16'h0, 1'b0);

    // random single-flit traffic
    for (int k = 0; k < 80; k++) begin
      int src;
      logic [7:0] dest;
      src  = $urandom_range(0, 5);
      dest = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) dest[7:4] = 4'h5;
      single_msg(src, dest, 8'(k));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    chk(hits[0] > 0, "R5", hits[0], 1);
    chk(hits[1] > 0, "R5", hits[1], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule